// File: doc/BRIEF.md
# Task-Aware Delayed Call Return Address

In a pipeline that interleaves several hardware tasks, a delayed call still runs the instructions that sit behind it in the pipeline before control moves to the target. When the return address assumes a fixed number of those instructions, interleaving breaks it, because some of the trailing slots belong to other tasks. This block looks at the trailing pipeline stages and counts only the entries that are valid and carry the calling task's tag. It then adds that count to the caller's next PC. The result points just past the delay-slot instructions that belong to the caller. Every delayed-call form uses the same rule.

On a call strobe, the block samples the caller's tag, its next PC and the valid and tag vectors of the trailing stages. It registers the sum, which appears on the output one clock later and holds until the next strobe. Instruction decode and the write of the link register take place outside this block.

Top module: `dcr_return_addr`

## Requirements
- R1: While `rst_n` is low, `ret_addr` is zero.
- R2: When `call_stb` is high at a rising clock edge, `ret_addr` from that edge on equals `call_next_pc` plus the number of counted trailing stages, all taken from that edge.
- R3: A trailing stage is counted only when its valid bit is 1 and its tag equals `call_task`. A stage whose valid bit is 0, because it is a bubble or was flushed, is never counted, whatever its tag holds.
- R4: The offset ranges from 0 to 3. No counted stages gives exactly `call_next_pc`, and three counted stages give `call_next_pc + 3`.
- R5: The addition wraps modulo 2^PC_W, which is 2^16 by default. For example, 0xFFFF plus 2 gives 0x0001.
- R6: At an edge where `call_stb` is low, `ret_addr` keeps its value, whatever the other inputs do.
- R7: Trailing stage k uses valid bit `stg_vld[k]` and tag bits `stg_tag[2k+1:2k]`, for k from 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to `clk` |
| call_stb | input | 1 | Delayed call issues this cycle |
| call_task | input | 2 | Task tag of the calling instruction |
| call_next_pc | input | 16 | PC of the instruction after the call |
| stg_vld | input | 3 | Valid bit of each trailing stage |
| stg_tag | input | 6 | Packed task tags of the trailing stages, 2 bits per stage |
| ret_addr | output | 16 | Registered return address |

## Verification
A carry out of the top PC bit can come at the same time as the largest offset. The bench provokes this by driving next-PC values of 0xFFFD and 0xFFFF against every combination of valid bits and tags, and compares the result with a sum it truncates to 16 bits. A second overlap is a change of pipeline contents in the cycle right after a strobe. The bench scrambles every input with the strobe low and checks that the captured address does not move.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  // Default geometry of the trailing-stage window
  localparam int unsigned DCR_PC_W   = 16;
  localparam int unsigned DCR_TAG_W  = 2;
  localparam int unsigned DCR_N_STG  = 3;
endpackage

// File: rtl/dcr_stage_match.sv
module dcr_stage_match #(
  parameter int unsigned N_STG = dcr_pkg::DCR_N_STG,
  parameter int unsigned TAG_W = dcr_pkg::DCR_TAG_W
) (
  input  logic [N_STG-1:0]       stg_vld,
  input  logic [N_STG*TAG_W-1:0] stg_tag,
  input  logic [TAG_W-1:0]       cur_tag,
  output logic [N_STG-1:0]       hit
);
  // One comparator per trailing stage; bubbles never match
  for (genvar k = 0; k < N_STG; k++) begin : g_stg
    assign hit[k] = stg_vld[k] && (stg_tag[k*TAG_W +: TAG_W] == cur_tag);
  end
endmodule

// File: rtl/dcr_popcount.sv
module dcr_popcount #(
  parameter int unsigned N     = dcr_pkg::DCR_N_STG,
  parameter int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     bits,
  output logic [CNT_W-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CNT_W'(bits[i]);
    end
  end
endmodule

// File: rtl/dcr_ret_reg.sv
module dcr_ret_reg #(
  parameter int unsigned PC_W  = dcr_pkg::DCR_PC_W,
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PC_W-1:0]  base,
  input  logic [CNT_W-1:0] ofs,
  output logic [PC_W-1:0]  q
);
  logic [PC_W-1:0] q_nxt;

  // Next state: modular sum on enable, otherwise hold
  always_comb begin
    q_nxt = q;
    if (en) begin
      q_nxt = base + {{(PC_W-CNT_W){1'b0}}, ofs};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/dcr_return_addr.sv
module dcr_return_addr #(
  parameter int unsigned PC_W  = dcr_pkg::DCR_PC_W,
  parameter int unsigned TAG_W = dcr_pkg::DCR_TAG_W,
  parameter int unsigned N_STG = dcr_pkg::DCR_N_STG
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   call_stb,
  input  logic [TAG_W-1:0]       call_task,
  input  logic [PC_W-1:0]        call_next_pc,
  input  logic [N_STG-1:0]       stg_vld,
  input  logic [N_STG*TAG_W-1:0] stg_tag,
  output logic [PC_W-1:0]        ret_addr
);
  localparam int unsigned CNT_W = $clog2(N_STG + 1);

  logic [N_STG-1:0] same_task;
  logic [CNT_W-1:0] slot_cnt;

  dcr_stage_match #(.N_STG(N_STG), .TAG_W(TAG_W)) u_match (
    .stg_vld (stg_vld),
    .stg_tag (stg_tag),
    .cur_tag (call_task),
    .hit     (same_task)
  );

  dcr_popcount #(.N(N_STG), .CNT_W(CNT_W)) u_cnt (
    .bits (same_task),
    .cnt  (slot_cnt)
  );

  dcr_ret_reg #(.PC_W(PC_W), .CNT_W(CNT_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (call_stb),
    .base  (call_next_pc),
    .ofs   (slot_cnt),
    .q     (ret_addr)
  );
endmodule

// File: rtl/dcr_return_addr_chk.sv
module dcr_return_addr_chk #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned TAG_W = 2,
  parameter int unsigned N_STG = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   call_stb,
  input logic [TAG_W-1:0]       call_task,
  input logic [PC_W-1:0]        call_next_pc,
  input logic [N_STG-1:0]       stg_vld,
  input logic [N_STG*TAG_W-1:0] stg_tag,
  input logic [PC_W-1:0]        ret_addr
);
  logic [N_STG-1:0] own_slot;
  always_comb begin
    for (int k = 0; k < N_STG; k++) begin
      own_slot[k] = stg_vld[k] && (stg_tag[k*TAG_W +: TAG_W] == call_task);
    end
  end

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_zero_chk: assert (ret_addr == '0);
    end
  end

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !call_stb |=> $stable(ret_addr));

  // R2
  sum_on_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_stb |=> ret_addr == PC_W'($past(call_next_pc) + PC_W'($countones($past(own_slot)))));

  // R3
  bubbles_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_stb && stg_vld == '0) |=> ret_addr == $past(call_next_pc));

  // R4
  offset_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_stb |=> PC_W'(ret_addr - $past(call_next_pc)) <= PC_W'(N_STG));
endmodule

bind dcr_return_addr dcr_return_addr_chk #(.PC_W(PC_W), .TAG_W(TAG_W), .N_STG(N_STG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .call_stb     (call_stb),
  .call_task    (call_task),
  .call_next_pc (call_next_pc),
  .stg_vld      (stg_vld),
  .stg_tag      (stg_tag),
  .ret_addr     (ret_addr)
);

// File: tb/test_dcr_return_addr.sv
`timescale 1ns/1ps
module test_dcr_return_addr;
  logic        clk;
  logic        rst_n;
  logic        call_stb;
  logic [1:0]  call_task;
  logic [15:0] call_next_pc;
  logic [2:0]  stg_vld;
  logic [5:0]  stg_tag;
  logic [15:0] ret_addr;

  int n_vec;
  int n_bad;
  bit done;

  dcr_return_addr i_dcr_return_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .call_stb     (call_stb),
    .call_task    (call_task),
    .call_next_pc (call_next_pc),
    .stg_vld      (stg_vld),
    .stg_tag      (stg_tag),
    .ret_addr     (ret_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ret_addr=%h expected=%h", req, act, exp);
    end
  endtask

  // One strobed call followed by one idle cycle with scrambled inputs
  task automatic apply(input logic [1:0] tk, input logic [15:0] pc,
                       input logic [2:0] vld, input logic [5:0] tg);
    int cnt;
    bit bubble_tag;
    logic [15:0] exp;
    string req;
    cnt = 0;
    bubble_tag = 0;
    // R7: stage k -> vld[k], tg[2k+1:2k]
    for (int k = 0; k < 3; k++) begin
      if (tg[2*k +: 2] == tk) begin
        if (vld[k]) cnt++;
        else bubble_tag = 1;
      end
    end
    exp = 16'((32'(pc) + 32'(cnt)) % 32'h10000);
    if (32'(pc) + 32'(cnt) > 32'hFFFF) req = "R5";
    else if (cnt == 3 || cnt == 0) req = "R4";
    else if (bubble_tag) req = "R3";
    else req = "R2";
    @(negedge clk);
    call_stb = 1'b1; call_task = tk; call_next_pc = pc; stg_vld = vld; stg_tag = tg;
    @(negedge clk);
    check(req, ret_addr, exp);
    call_stb = 1'b0; call_task = ~tk; call_next_pc = ~pc; stg_vld = 3'b111; stg_tag = {3{~tk}};
    @(negedge clk);
    check("R6", ret_addr, exp);
  endtask

  initial begin
    logic [15:0] pcs [4];
    pcs[0] = 16'h0000; pcs[1] = 16'h1234; pcs[2] = 16'hFFFD; pcs[3] = 16'hFFFF;
    n_vec = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; call_stb = 1'b1; call_task = 2'd1; call_next_pc = 16'hABCD;
    stg_vld = 3'b111; stg_tag = 6'h15;
    repeat (3) @(negedge clk);
    check("R1", ret_addr, 16'h0000);
    call_stb = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", ret_addr, 16'h0000);
    for (int p = 0; p < 4; p++)
      for (int t = 0; t < 4; t++)
        for (int v = 0; v < 8; v++)
          for (int g = 0; g < 64; g++)
            apply(2'(t), pcs[p], 3'(v), 6'(g));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: ret_addr=%h expected=completion", ret_addr);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule